// File: doc/BRIEF.md
# PLL Clock Control Sequencer

This block holds the digital control state that sits next to an on-chip PLL. Software programs a 5-bit multiplier code and a status word. The status word carries a 2-bit post-divider code and a PLL power-down bit. The block decides whether the downstream clock mux takes the reference clock (bypass) or the PLL output. It models PLL lock with a down-counter that restarts whenever a new nonzero multiplier is written. It produces the CPU clock as a one-cycle tick at the divided rate.

The block enforces the safe programming order:
- The multiplier may only be changed while the post-divider is at its slowest setting.
- The PLL output is used only after lock.
- The divide-by-one setting is kept away from a running PLL.
- The PLL may be powered down only after the multiplier has been cleared.

Writes that break these rules change nothing and pulse an error flag. All writes need an unlock input. Only the external and watchdog resets restore the registers. The debugger and missing-clock resets restart only the divider and the error flag.

The divider phase counter runs on the reference clock. The block exports the selected source and the effective multiplication factor for the analog mux. A new divider code takes effect only at the end of the current output period.

Top module: `pllseq_ctrl`

## Requirements
- R1: Writing address 0 stores wr_data_i[4:0] as the multiplier code n. While the PLL path is selected, mult_ratio_o reads n+1 (2 to 32). Otherwise it reads 1.
- R2: Writing address 1 sets the post-divider code from wr_data_i[1:0] and the power-down bit from wr_data_i[2]. Codes 0, 1, 2, 3 give one cpu_tick_o pulse every 8, 4, 2 and 1 input clock cycles.
- R3: After external reset, the multiplier code is 0, the divider code is 0, power-down is 0, and locked_o, pll_sel_o and err_o are 0.
- R4: A multiplier write is accepted only while the divider code is 0 and, if the PLL is powered down, only for the value 0. A rejected write leaves all registers unchanged and raises err_o for exactly the one cycle after the write edge.
- R5: After an accepted nonzero multiplier write, locked_o and pll_sel_o stay low until lock, and mult_ratio_o stays 1. Writing 0 drops lock and returns to bypass.
- R6: locked_o rises LOCK_CYCLES clock edges after the edge that accepted a nonzero multiplier. pll_sel_o rises with it.
- R7: While the PLL is running and not yet locked, only divider code 0 is accepted. Once locked, codes 0 to 2 are accepted and code 3 is rejected with err_o. In bypass or power-down, all four codes are accepted.
- R8: Setting power-down is rejected with err_o unless the multiplier code is 0. While powered down, the tick comes from the input clock through the divider.
- R9: A write with wr_unlock_i low changes nothing and does not raise err_o.
- R10: The external and watchdog resets restore the registers and the lock state. The debugger and missing-clock resets leave the multiplier, the divider code, power-down and locked_o unchanged.
- R11: A divider code change takes effect only when the current output period ends. The period in progress at the change keeps its old length.
- R12: A status write that lands on the same edge as lock completion is judged against the pre-edge, unlocked state. Such a write raising the divider is therefore rejected, and the same write one cycle later is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference input clock |
| ext_rst_n_i | input | 1 | External reset, active low; restores registers |
| wdog_rst_n_i | input | 1 | Watchdog reset, active low; restores registers |
| dbg_rst_n_i | input | 1 | Debugger reset, active low; divider and error flag only |
| mclk_rst_n_i | input | 1 | Missing-clock reset, active low; divider and error flag only |
| wr_en_i | input | 1 | Register write strobe |
| wr_unlock_i | input | 1 | Write protection open when high |
| wr_addr_i | input | 1 | 0 = multiplier register, 1 = status register |
| wr_data_i | input | 5 | Write data |
| mult_o | output | 5 | Stored multiplier code |
| divsel_o | output | 2 | Stored post-divider code |
| pll_off_o | output | 1 | PLL power-down bit |
| locked_o | output | 1 | Lock flag |
| pll_sel_o | output | 1 | 1 = PLL output selected, 0 = bypass |
| mult_ratio_o | output | 6 | Effective multiplication of the reference |
| err_o | output | 1 | One-cycle pulse after a rejected write |
| cpu_tick_o | output | 1 | One pulse per CPU clock period |

## Verification
Lock completion and a status write can fall on the same clock edge. At that edge the legality check sees the old unlocked state, while the lock flag changes under it. The bench times a divider-raise write so that it is sampled on exactly the LOCK_CYCLES-th edge after the multiplier write. It expects a rejection with locked_o already high afterwards, and then expects the same write one cycle later to be accepted. A second overlap is a divider change arriving mid-period. It is judged by the length of the period that straddles the write: the old length is expected, and the new length after that.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int unsigned MULT_W    = 5;
  localparam int unsigned DSEL_W    = 2;
  localparam int unsigned RATIO_MAX = 8;
  localparam int unsigned DCNT_W    = $clog2(RATIO_MAX);
  localparam logic        ADDR_MULT = 1'b0;

  typedef enum logic [DSEL_W-1:0] {
    DIV8 = 2'd0,
    DIV4 = 2'd1,
    DIV2 = 2'd2,
    DIV1 = 2'd3
  } dsel_e;

  typedef struct packed {
    logic [MULT_W-1:0] mult;
    dsel_e             dsel;
    logic              off;
  } cfg_t;

  function automatic logic [DCNT_W:0] dsel_ratio(input dsel_e s);
    logic [DSEL_W-1:0] sh;
    sh = s;
    return (DCNT_W+1)'(RATIO_MAX) >> sh;
  endfunction

endpackage

// File: rtl/pllseq_rst_sync.sv
module pllseq_rst_sync (
  input  logic clk_i,
  input  logic raw_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge raw_n_i) begin
    if (!raw_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/pllseq_regs.sv
module pllseq_regs
  import pllseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              reg_rst_n_i,
  input  logic              sys_rst_n_i,
  input  logic              wr_en_i,
  input  logic              wr_unlock_i,
  input  logic              wr_addr_i,
  input  logic [MULT_W-1:0] wr_data_i,
  input  logic              locked_i,
  output cfg_t              cfg_o,
  output logic              lock_ld_o,
  output logic              lock_clr_o,
  output logic              err_o
);

  cfg_t  cfg_q, cfg_d;
  logic  err_q, err_d;
  logic  wr_ok;
  dsel_e new_dsel;
  logic  new_off;
  logic  pll_run_next;
  logic  mult_bad;
  logic  stat_bad;

  // decode of the incoming write
  always_comb begin
    wr_ok        = wr_en_i && wr_unlock_i;
    new_dsel     = dsel_e'(wr_data_i[DSEL_W-1:0]);
    new_off      = wr_data_i[DSEL_W];
    pll_run_next = (cfg_q.mult != '0) && !new_off;
    mult_bad     = (cfg_q.dsel != DIV8) || (cfg_q.off && (wr_data_i != '0));
    stat_bad     = 1'b0;
    if (new_off && !cfg_q.off && (cfg_q.mult != '0)) begin
      stat_bad = 1'b1;
    end else if (pll_run_next) begin
      if (!locked_i && (new_dsel != DIV8)) stat_bad = 1'b1;
      if (locked_i && (new_dsel == DIV1))  stat_bad = 1'b1;
    end
  end

  // next state
  always_comb begin
    cfg_d      = cfg_q;
    lock_ld_o  = 1'b0;
    lock_clr_o = 1'b0;
    err_d      = 1'b0;
    if (wr_ok) begin
      if (wr_addr_i == ADDR_MULT) begin
        if (mult_bad) begin
          err_d = 1'b1;
        end else begin
          cfg_d.mult = wr_data_i;
          lock_ld_o  = (wr_data_i != '0);
          lock_clr_o = (wr_data_i == '0);
        end
      end else begin
        if (stat_bad) begin
          err_d = 1'b1;
        end else begin
          cfg_d.dsel = new_dsel;
          cfg_d.off  = new_off;
          lock_clr_o = new_off;
        end
      end
    end
  end

  // configuration registers: external / watchdog reset only
  always_ff @(posedge clk_i or negedge reg_rst_n_i) begin
    if (!reg_rst_n_i) begin
      cfg_q.mult <= '0;
      cfg_q.dsel <= DIV8;
      cfg_q.off  <= 1'b0;
    end else if (wr_ok) begin
      cfg_q <= cfg_d;
    end
  end

  // error pulse: any reset source
  always_ff @(posedge clk_i or negedge sys_rst_n_i) begin
    if (!sys_rst_n_i) err_q <= 1'b0;
    else              err_q <= err_d;
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  AST_MULT_NEEDS_DIV8: assert property (@(posedge clk_i) disable iff (!(reg_rst_n_i && sys_rst_n_i))
    (cfg_q.mult != $past(cfg_q.mult)) |-> ($past(cfg_q.dsel) == DIV8)); // R4
  AST_ERR_KEEPS_REGS: assert property (@(posedge clk_i) disable iff (!(reg_rst_n_i && sys_rst_n_i))
    err_q |-> $stable(cfg_q)); // R4
  AST_DIV1_ONLY_BYPASS: assert property (@(posedge clk_i) disable iff (!(reg_rst_n_i && sys_rst_n_i))
    (cfg_q.dsel == DIV1) |-> ((cfg_q.mult == '0) || cfg_q.off)); // R7
  AST_OFF_NEEDS_ZERO: assert property (@(posedge clk_i) disable iff (!(reg_rst_n_i && sys_rst_n_i))
    cfg_q.off |-> (cfg_q.mult == '0)); // R8

endmodule

// File: rtl/pllseq_lock.sv
module pllseq_lock #(
  parameter int unsigned LOCK_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic ld_i,
  input  logic clr_i,
  output logic locked_o
);

  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             locked_q, locked_d;

  always_comb begin
    cnt_d    = cnt_q;
    locked_d = locked_q;
    if (clr_i) begin
      cnt_d    = '0;
      locked_d = 1'b0;
    end else if (ld_i) begin
      cnt_d    = CNT_W'(LOCK_CYCLES);
      locked_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      locked_q <= locked_d;
    end
  end

  assign locked_o = locked_q;

  AST_LOCK_AFTER_COUNT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(locked_q) |-> ($past(cnt_q) == CNT_W'(1))); // R6
  AST_LOAD_DROPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ld_i |=> !locked_q); // R5

endmodule

// File: rtl/pllseq_div.sv
module pllseq_div
  import pllseq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_n_i,
  input  dsel_e dsel_i,
  output logic  tick_o
);

  logic [DCNT_W-1:0] cnt_q, cnt_d;
  dsel_e             act_q, act_d;
  logic              tick_q;
  logic              last;

  always_comb begin
    last  = ({1'b0, cnt_q} == (dsel_ratio(act_q) - (DCNT_W+1)'(1)));
    cnt_d = last ? '0 : cnt_q + DCNT_W'(1);
    act_d = last ? dsel_i : act_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q  <= '0;
      act_q  <= DIV8;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      tick_q <= last;
    end
  end

  assign tick_o = tick_q;

  AST_SWITCH_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (act_q != $past(act_q)) |-> (cnt_q == '0)); // R11
  AST_TICK_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tick_q |-> (cnt_q == '0)); // R2

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              ext_rst_n_i,
  input  logic              wdog_rst_n_i,
  input  logic              dbg_rst_n_i,
  input  logic              mclk_rst_n_i,
  input  logic              wr_en_i,
  input  logic              wr_unlock_i,
  input  logic              wr_addr_i,
  input  logic [MULT_W-1:0] wr_data_i,
  output logic [MULT_W-1:0] mult_o,
  output logic [DSEL_W-1:0] divsel_o,
  output logic              pll_off_o,
  output logic              locked_o,
  output logic              pll_sel_o,
  output logic [MULT_W:0]   mult_ratio_o,
  output logic              err_o,
  output logic              cpu_tick_o
);

  logic reg_raw_n, sys_raw_n;
  logic reg_rst_n, sys_rst_n;
  cfg_t cfg;
  logic lock_ld, lock_clr, locked;

  assign reg_raw_n = ext_rst_n_i & wdog_rst_n_i;
  assign sys_raw_n = reg_raw_n & dbg_rst_n_i & mclk_rst_n_i;

  pllseq_rst_sync u_reg_sync (.clk_i(clk_i), .raw_n_i(reg_raw_n), .rst_n_o(reg_rst_n));
  pllseq_rst_sync u_sys_sync (.clk_i(clk_i), .raw_n_i(sys_raw_n), .rst_n_o(sys_rst_n));

  pllseq_regs u_regs (
    .clk_i       (clk_i),
    .reg_rst_n_i (reg_rst_n),
    .sys_rst_n_i (sys_rst_n),
    .wr_en_i     (wr_en_i),
    .wr_unlock_i (wr_unlock_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .locked_i    (locked),
    .cfg_o       (cfg),
    .lock_ld_o   (lock_ld),
    .lock_clr_o  (lock_clr),
    .err_o       (err_o)
  );

  pllseq_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i    (clk_i),
    .rst_n_i  (reg_rst_n),
    .ld_i     (lock_ld),
    .clr_i    (lock_clr),
    .locked_o (locked)
  );

  pllseq_div u_div (
    .clk_i   (clk_i),
    .rst_n_i (sys_rst_n),
    .dsel_i  (cfg.dsel),
    .tick_o  (cpu_tick_o)
  );

  assign mult_o       = cfg.mult;
  assign divsel_o     = cfg.dsel;
  assign pll_off_o    = cfg.off;
  assign locked_o     = locked;
  assign pll_sel_o    = locked && (cfg.mult != '0) && !cfg.off;
  assign mult_ratio_o = pll_sel_o ? ({1'b0, cfg.mult} + (MULT_W+1)'(1)) : (MULT_W+1)'(1);

  AST_LOCK_NEVER_OFF: assert property (@(posedge clk_i) disable iff (!(reg_rst_n && sys_rst_n))
    cfg.off |-> !locked); // R8

endmodule

// File: tb/pllseq_ctrl_tb.sv
module pllseq_ctrl_tb;

  localparam int LK = 6;

  logic       clk = 1'b0;
  logic       ext_rst_n, wdog_rst_n, dbg_rst_n, mclk_rst_n;
  logic       wr_en, wr_unlock, wr_addr;
  logic [4:0] wr_data;
  logic [4:0] mult;
  logic [1:0] divsel;
  logic       pll_off, locked, pll_sel, err, tick;
  logic [5:0] ratio;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  pllseq_ctrl #(.LOCK_CYCLES(LK)) u_dut (
    .clk_i(clk), .ext_rst_n_i(ext_rst_n), .wdog_rst_n_i(wdog_rst_n),
    .dbg_rst_n_i(dbg_rst_n), .mclk_rst_n_i(mclk_rst_n),
    .wr_en_i(wr_en), .wr_unlock_i(wr_unlock), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .mult_o(mult), .divsel_o(divsel), .pll_off_o(pll_off), .locked_o(locked),
    .pll_sel_o(pll_sel), .mult_ratio_o(ratio), .err_o(err), .cpu_tick_o(tick)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic period(output int p);
    int g = 0;
    @(negedge clk);
    while (!tick && g < 40) begin @(negedge clk); g++; end
    p = 0;
    do begin @(negedge clk); p++; end while (!tick && p < 40);
  endtask

  task automatic pulse_rst(input int which);
    @(negedge clk);
    case (which)
      0: ext_rst_n  = 1'b0;
      1: wdog_rst_n = 1'b0;
      2: dbg_rst_n  = 1'b0;
      default: mclk_rst_n = 1'b0;
    endcase
    repeat (3) @(negedge clk);
    ext_rst_n = 1'b1; wdog_rst_n = 1'b1; dbg_rst_n = 1'b1; mclk_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R3", "mult", mult, 0);
    chk("R3", "divsel", divsel, 0);
    chk("R3", "pll_off", pll_off, 0);
    chk("R3", "locked", locked, 0);
    chk("R3", "pll_sel", pll_sel, 0);
    chk("R3", "err", err, 0);
    chk("R1", "bypass ratio", ratio, 1);
  endtask

  task automatic t_bypass_div();
    int p;
    for (int s = 0; s < 4; s++) begin
      wr(1'b1, 5'(s));
      chk("R7", "bypass divsel accepted", divsel, s);
      period(p); period(p);
      chk("R2", "bypass period", p, 8 >> s);
    end
    wr(1'b1, 5'd0);
    period(p); period(p);
    chk("R2", "back to /8", p, 8);
  endtask

  task automatic t_switch_boundary();
    int n = 0;
    @(negedge clk);
    while (!tick) @(negedge clk);
    do begin
      @(negedge clk); n++;
      if (n == 1) begin wr_en = 1'b1; wr_addr = 1'b1; wr_data = 5'd3; end
      if (n == 2) wr_en = 1'b0;
    end while (!tick && n < 40);
    chk("R11", "period straddling switch", n, 8);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 40);
    chk("R11", "first period after switch", n, 1);
    wr(1'b1, 5'd0);
  endtask

  task automatic t_protect();
    wr_unlock = 1'b0;
    wr(1'b0, 5'd5);
    chk("R9", "locked-out mult", mult, 0);
    chk("R9", "no err on protected write", err, 0);
    wr(1'b1, 5'd2);
    chk("R9", "locked-out divsel", divsel, 0);
    wr_unlock = 1'b1;
  endtask

  task automatic t_lock();
    wr(1'b0, 5'd9);
    chk("R1", "mult stored", mult, 9);
    repeat (LK - 1) @(negedge clk);
    chk("R5", "locked before count", locked, 0);
    chk("R5", "bypass before lock", pll_sel, 0);
    chk("R5", "ratio before lock", ratio, 1);
    @(negedge clk);
    chk("R6", "locked at count", locked, 1);
    chk("R6", "pll selected at count", pll_sel, 1);
    chk("R1", "ratio after lock", ratio, 10);
  endtask

  task automatic t_locked_div();
    int p;
    wr(1'b1, 5'd1);
    chk("R7", "locked /4 accepted", divsel, 1);
    period(p); period(p);
    chk("R2", "locked /4 period", p, 4);
    wr(1'b1, 5'd2);
    chk("R7", "locked /2 accepted", divsel, 2);
    period(p); period(p);
    chk("R2", "locked /2 period", p, 2);
    wr(1'b1, 5'd3);
    chk("R7", "locked /1 err", err, 1);
    chk("R7", "locked /1 rejected", divsel, 2);
    wr(1'b0, 5'd3);
    chk("R4", "mult write divsel!=0 err", err, 1);
    chk("R4", "mult unchanged", mult, 9);
    chk("R4", "lock kept", locked, 1);
    @(negedge clk);
    chk("R4", "err one cycle", err, 0);
    wr(1'b1, 5'd0);
    wr(1'b0, 5'd0);
    chk("R5", "mult 0 drops lock", locked, 0);
    chk("R5", "mult 0 bypass", pll_sel, 0);
  endtask

  task automatic t_relock_div();
    wr(1'b0, 5'd31);
    wr(1'b1, 5'd1);
    chk("R7", "relock raise err", err, 1);
    chk("R7", "relock raise rejected", divsel, 0);
    repeat (LK) @(negedge clk);
    chk("R1", "max ratio", ratio, 32);
  endtask

  task automatic t_collision();
    wr(1'b0, 5'd7);
    repeat (LK - 2) @(negedge clk);
    wr(1'b1, 5'd1);
    chk("R12", "same-edge write err", err, 1);
    chk("R12", "same-edge write rejected", divsel, 0);
    chk("R12", "lock completed", locked, 1);
    wr(1'b1, 5'd1);
    chk("R12", "next write accepted", divsel, 1);
    wr(1'b1, 5'd0);
  endtask

  task automatic t_off();
    int p;
    wr(1'b1, 5'd4);
    chk("R8", "off with mult err", err, 1);
    chk("R8", "off rejected", pll_off, 0);
    wr(1'b0, 5'd0);
    wr(1'b1, 5'd7);
    chk("R8", "off accepted", pll_off, 1);
    chk("R7", "/1 while off", divsel, 3);
    period(p); period(p);
    chk("R8", "off path period", p, 1);
    wr(1'b1, 5'd4);
    wr(1'b0, 5'd2);
    chk("R4", "nonzero mult while off err", err, 1);
    chk("R4", "mult kept 0", mult, 0);
    wr(1'b1, 5'd0);
    chk("R8", "off cleared", pll_off, 0);
  endtask

  task automatic t_resets();
    wr(1'b0, 5'd5);
    repeat (LK) @(negedge clk);
    wr(1'b1, 5'd2);
    pulse_rst(2);
    chk("R10", "dbg keeps mult", mult, 5);
    chk("R10", "dbg keeps divsel", divsel, 2);
    chk("R10", "dbg keeps lock", locked, 1);
    pulse_rst(3);
    chk("R10", "mclk keeps divsel", divsel, 2);
    chk("R10", "mclk keeps lock", locked, 1);
    pulse_rst(1);
    chk("R10", "wdog clears mult", mult, 0);
    chk("R10", "wdog clears divsel", divsel, 0);
    chk("R10", "wdog clears lock", locked, 0);
  endtask

  initial begin
    ext_rst_n = 1'b0; wdog_rst_n = 1'b1; dbg_rst_n = 1'b1; mclk_rst_n = 1'b1;
    wr_en = 1'b0; wr_unlock = 1'b1; wr_addr = 1'b0; wr_data = '0;
    repeat (5) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bypass_div();
    t_switch_boundary();
    t_protect();
    t_lock();
    t_locked_div();
    t_relock_div();
    t_collision();
    t_off();
    t_resets();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule